// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits on the host side of an 8-bit asynchronous NAND flash bus and turns one high-level request into the right string of bus cycles. A request names an operation (page read, page program or block erase), a 32-bit address, a byte count and whether the spare area is meant. The sequencer then drives command, address and data cycles with the right latch-enable levels and strobe pulse widths. It waits out the device's busy period, reads back status after a program or erase, and reports one completion code.

Every strobe width, setup interval and busy limit is a parameter counted in system clocks. Before any bus activity, the block screens each write-type request. It checks the target block against a host-supplied valid-block mask and checks the target page against its partial-program budget. A refused request finishes with a reject code and leaves chip enable high.

Top module: `nand_seq`

## Requirements
- R1: A command byte is transferred with nand_cle=1, nand_ale=0, nand_ce_n=0 and nand_re_n=1 while nand_we_n pulses. The opening command is 00h for a main-area read, 50h for a spare-area read, 80h for program and 60h for erase. The confirm command is 10h for program and D0h for erase, and the status command is 70h.
- R2: The address phase is exactly four nand_we_n pulses with nand_ale=1 and nand_cle=0. The bytes go out as req_addr[7:0], [15:8], [23:16], [31:24] in that order.
- R3: A program sends req_len data bytes with both latch enables low. Each byte is taken from wr_data when it is launched, and wr_take pulses once per byte taken.
- R4: After the busy period, a read performs req_len nand_re_n pulses with nand_we_n high and both latch enables low. It presents each sampled nand_dq_i byte on rd_data with a one-cycle rd_valid.
- R5: nand_wp_n is high for the whole of a program or erase transaction and low while idle or reading.
- R6: Each write or read strobe stays low for exactly T_LO clocks. Latch enables never change while a strobe is low, and the two strobes are never low together.
- R7: nand_ce_n is high and req_ready is high whenever no request is in progress. req_ready is low while one is.
- R8: nand_rb_n passes through a two-flop synchronizer and is ignored for T_WB clocks once the busy wait starts. If it is still low after PROG_TO clocks of polling (program), ERASE_TO (erase) or RD_TO (read), the request ends with the timeout code and no status read.
- R9: After a program or erase busy period, the block issues 70h and reads one byte. Bit 0 set gives the fail code, clear gives the ok code.
- R10: The block index is req_addr[8+PG_W +: BLK_W] and the page index is req_addr[8 +: PG_W]. A program or erase to a nonzero block whose blk_ok_mask bit is 0 is rejected with no bus activity. Block 0 is always accepted.
- R11: Each page accepts at most MAIN_NOP main-area and SPARE_NOP spare-area programs, counted separately, and later ones are rejected. An accepted erase restores the budget of every page in its block.
- R12: done pulses for one clock at the end of every request, with done_code 0 = ok, 1 = device fail, 2 = timeout, 3 = reject. req_op is encoded 0 = read, 1 = program, 2 = erase, and 3 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted on valid and ready |
| req_op | input | 2 | Operation code |
| req_addr | input | 32 | Four address bytes, lowest first on the bus |
| req_len | input | LEN_W | Data byte count for read or program |
| req_spare | input | 1 | Target the spare area |
| blk_ok_mask | input | NBLK | One bit per block, 1 = usable |
| wr_data | input | 8 | Next program data byte |
| wr_take | output | 1 | Pulse: current wr_data byte consumed |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| done | output | 1 | Pulse: request finished |
| done_code | output | 2 | Completion code |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb_n | input | 1 | Ready/busy, low = busy |

## Verification
The hardest case to reach is the narrow interval just after a confirm command. In it, ready/busy has not yet fallen, and a sequencer that polled too early would see the device as ready. The bench's flash model lowers ready/busy a couple of clocks after the confirm strobe rises. The scoreboard then checks that the status command arrives only after the model has released busy. Exhausting the partial-program budget, and seeing an erase restore it, takes long chains of back-to-back programs to one page. The bench runs those chains for both the main and the spare counters.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_RSVD = 2'd3} op_t;
  typedef enum logic [1:0] {BK_CMD = 2'd0, BK_ADDR = 2'd1, BK_DIN = 2'd2, BK_DOUT = 2'd3} bkind_t;
  typedef enum logic [1:0] {DC_OK = 2'd0, DC_FAIL = 2'd1, DC_TMO = 2'd2, DC_REJ = 2'd3} dcode_t;
  localparam logic [7:0] CMD_RD_MAIN = 8'h00;
  localparam logic [7:0] CMD_RD_SPARE = 8'h50;
  localparam logic [7:0] CMD_PROG = 8'h80;
  localparam logic [7:0] CMD_PROG_GO = 8'h10;
  localparam logic [7:0] CMD_ERASE = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS = 8'h70;
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nandseq_pkg::*;
#(
  parameter int T_SU = 2,
  parameter int T_LO = 3,
  parameter int T_HI = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  bkind_t     kind,
  input  logic [7:0] tx,
  input  logic [7:0] dq_i,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_o,
  output logic       dq_oe,
  output logic [7:0] rx,
  output logic       fin
);
  localparam int TMAX = (T_SU > T_LO) ? ((T_SU > T_HI) ? T_SU : T_HI)
                                      : ((T_LO > T_HI) ? T_LO : T_HI);
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_LOW, P_HIGH} ph_t;
  ph_t ph;
  logic [CW-1:0] cnt;
  logic is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= P_IDLE; cnt <= '0; is_rd <= 1'b0; fin <= 1'b0;
      cle <= 1'b0; ale <= 1'b0; we_n <= 1'b1; re_n <= 1'b1;
      dq_o <= '0; dq_oe <= 1'b0; rx <= '0;
    end else begin
      fin <= 1'b0;
      case (ph)
        P_IDLE: if (go) begin
          cle   <= (kind == BK_CMD);
          ale   <= (kind == BK_ADDR);
          dq_o  <= tx;
          dq_oe <= (kind != BK_DOUT);
          is_rd <= (kind == BK_DOUT);
          cnt   <= CW'(T_SU - 1);
          ph    <= P_SETUP;
        end
        P_SETUP: if (cnt == '0) begin
          if (is_rd) re_n <= 1'b0; else we_n <= 1'b0;
          cnt <= CW'(T_LO - 1);
          ph  <= P_LOW;
        end else cnt <= cnt - 1'b1;
        P_LOW: if (cnt == '0) begin
          we_n <= 1'b1; re_n <= 1'b1;
          if (is_rd) rx <= dq_i;
          cnt <= CW'(T_HI - 1);
          ph  <= P_HIGH;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          cle <= 1'b0; ale <= 1'b0; dq_oe <= 1'b0;
          fin <= 1'b1;
          ph  <= P_IDLE;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R6: latch enables frozen while either strobe is low
  a_r6_latch_frozen: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n) |-> ($stable(cle) && $stable(ale)));
  // R6: strobes never overlap
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  // R2: never both latch enables
  a_r2_latch_excl: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));
endmodule

// File: rtl/nand_busy_wait.sv
module nand_busy_wait #(
  parameter int T_WB = 20,
  parameter int TO_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [TO_W-1:0] limit,
  input  logic            rb_n,
  output logic            fin,
  output logic            tmo
);
  localparam int IW = $clog2(T_WB + 1);
  typedef enum logic [1:0] {W_IDLE, W_IGN, W_POLL} ws_t;
  ws_t ws;
  logic rb_q1, rb_q2;
  logic [IW-1:0] ign;
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_q1 <= 1'b1; rb_q2 <= 1'b1;
      ws <= W_IDLE; ign <= '0; cnt <= '0; fin <= 1'b0; tmo <= 1'b0;
    end else begin
      rb_q1 <= rb_n;
      rb_q2 <= rb_q1;
      fin <= 1'b0; tmo <= 1'b0;
      case (ws)
        W_IDLE: if (go) begin ws <= W_IGN; ign <= IW'(T_WB); cnt <= '0; end
        W_IGN: if (ign == '0) ws <= W_POLL; else ign <= ign - 1'b1;
        default: begin
          if (rb_q2) begin
            fin <= 1'b1; ws <= W_IDLE;
          end else if (cnt == limit) begin
            fin <= 1'b1; tmo <= 1'b1; ws <= W_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R8: polling counter never passes the active limit
  a_r8_poll_bound: assert property (@(posedge clk) disable iff (rst)
    (ws == W_POLL) |-> (cnt <= limit));
endmodule

// File: rtl/nand_guard.sv
module nand_guard
  import nandseq_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int PG_PER_BLK = 4,
  parameter int MAIN_NOP = 2,
  parameter int SPARE_NOP = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  op_t             op,
  input  logic [31:0]     addr,
  input  logic            spare,
  input  logic [NBLK-1:0] mask,
  input  logic            commit,
  output logic            reject
);
  localparam int BLK_W = $clog2(NBLK);
  localparam int PG_W = $clog2(PG_PER_BLK);
  localparam int NPAGE = NBLK * PG_PER_BLK;
  localparam int NMAX = (MAIN_NOP > SPARE_NOP) ? MAIN_NOP : SPARE_NOP;
  localparam int NC = $clog2(NMAX + 1);

  logic [NC-1:0] mcnt [NPAGE];
  logic [NC-1:0] scnt [NPAGE];
  logic [BLK_W-1:0] blk;
  logic [BLK_W+PG_W-1:0] idx;
  logic blk_bad, over;

  assign blk = addr[8+PG_W +: BLK_W];
  assign idx = addr[8 +: BLK_W+PG_W];
  assign blk_bad = (blk != '0) && !mask[blk];
  assign over = spare ? (scnt[idx] >= NC'(SPARE_NOP)) : (mcnt[idx] >= NC'(MAIN_NOP));

  always_comb begin
    case (op)
      OP_READ:  reject = 1'b0;
      OP_PROG:  reject = blk_bad || over;
      OP_ERASE: reject = blk_bad;
      default:  reject = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAGE; i++) begin mcnt[i] <= '0; scnt[i] <= '0; end
    end else if (commit) begin
      if (op == OP_PROG) begin
        if (spare) scnt[idx] <= scnt[idx] + 1'b1;
        else mcnt[idx] <= mcnt[idx] + 1'b1;
      end else if (op == OP_ERASE) begin
        for (int p = 0; p < PG_PER_BLK; p++) begin
          mcnt[{blk, PG_W'(p)}] <= '0;
          scnt[{blk, PG_W'(p)}] <= '0;
        end
      end
    end
  end

  // R11: budgets of the addressed page are never exceeded
  a_r11_budget: assert property (@(posedge clk) disable iff (rst)
    (mcnt[idx] <= NC'(MAIN_NOP)) && (scnt[idx] <= NC'(SPARE_NOP)));
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nandseq_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int PG_PER_BLK = 4,
  parameter int LEN_W = 10,
  parameter int T_SU = 2,
  parameter int T_LO = 3,
  parameter int T_HI = 2,
  parameter int T_WB = 20,
  parameter int PROG_TO = 100000,
  parameter int ERASE_TO = 600000,
  parameter int RD_TO = 5000,
  parameter int MAIN_NOP = 2,
  parameter int SPARE_NOP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_spare,
  input  logic [NBLK-1:0]  blk_ok_mask,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic [1:0]       done_code,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic             nand_wp_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_n
);
  localparam int TO_MAX = (PROG_TO > ERASE_TO) ? ((PROG_TO > RD_TO) ? PROG_TO : RD_TO)
                                               : ((ERASE_TO > RD_TO) ? ERASE_TO : RD_TO);
  localparam int TO_W = $clog2(TO_MAX + 1);

  typedef enum logic [3:0] {S_IDLE, S_CMD1, S_ADDR, S_DIN, S_CMD2, S_WAIT, S_DOUT, S_STAT, S_SREAD} st_t;
  st_t st;
  op_t op_q, req_op_t;
  logic [31:0] addr_q;
  logic [LEN_W-1:0] len_q, idx;
  logic spare_q, reject, commit;
  logic bc_go, bc_fin, bw_go, bw_fin, bw_tmo;
  bkind_t bc_kind;
  logic [7:0] bc_tx, bc_rx;
  logic [TO_W-1:0] bw_lim;

  assign req_op_t = op_t'(req_op);
  assign req_ready = (st == S_IDLE);
  assign commit = req_valid && req_ready && !reject;

  nand_guard #(.NBLK(NBLK), .PG_PER_BLK(PG_PER_BLK), .MAIN_NOP(MAIN_NOP), .SPARE_NOP(SPARE_NOP)) u_guard (
    .clk(clk), .rst(rst), .op(req_op_t), .addr(req_addr), .spare(req_spare),
    .mask(blk_ok_mask), .commit(commit), .reject(reject));

  nand_bus_cycle #(.T_SU(T_SU), .T_LO(T_LO), .T_HI(T_HI)) u_cycle (
    .clk(clk), .rst(rst), .go(bc_go), .kind(bc_kind), .tx(bc_tx), .dq_i(nand_dq_i),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .rx(bc_rx), .fin(bc_fin));

  nand_busy_wait #(.T_WB(T_WB), .TO_W(TO_W)) u_busy (
    .clk(clk), .rst(rst), .go(bw_go), .limit(bw_lim), .rb_n(nand_rb_n),
    .fin(bw_fin), .tmo(bw_tmo));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; op_q <= OP_READ; addr_q <= '0; len_q <= '0; idx <= '0; spare_q <= 1'b0;
      nand_ce_n <= 1'b1; nand_wp_n <= 1'b0; done <= 1'b0; done_code <= DC_OK;
      wr_take <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
      bc_go <= 1'b0; bc_kind <= BK_CMD; bc_tx <= '0; bw_go <= 1'b0; bw_lim <= '0;
    end else begin
      bc_go <= 1'b0; bw_go <= 1'b0; done <= 1'b0; wr_take <= 1'b0; rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (reject) begin
            done <= 1'b1; done_code <= DC_REJ;
          end else begin
            op_q <= req_op_t; addr_q <= req_addr; len_q <= req_len; spare_q <= req_spare;
            nand_ce_n <= 1'b0; nand_wp_n <= (req_op_t != OP_READ);
            st <= S_CMD1; bc_go <= 1'b1; bc_kind <= BK_CMD;
            case (req_op_t)
              OP_PROG:  bc_tx <= CMD_PROG;
              OP_ERASE: bc_tx <= CMD_ERASE;
              default:  bc_tx <= req_spare ? CMD_RD_SPARE : CMD_RD_MAIN;
            endcase
          end
        end
        S_CMD1: if (bc_fin) begin
          st <= S_ADDR; idx <= '0;
          bc_go <= 1'b1; bc_kind <= BK_ADDR; bc_tx <= addr_q[7:0];
        end
        S_ADDR: if (bc_fin) begin
          if (idx == LEN_W'(3)) begin
            if (op_q == OP_READ) begin
              st <= S_WAIT; bw_go <= 1'b1; bw_lim <= TO_W'(RD_TO);
            end else if (op_q == OP_PROG && len_q != '0) begin
              st <= S_DIN; idx <= '0; wr_take <= 1'b1;
              bc_go <= 1'b1; bc_kind <= BK_DIN; bc_tx <= wr_data;
            end else begin
              st <= S_CMD2; bc_go <= 1'b1; bc_kind <= BK_CMD;
              bc_tx <= (op_q == OP_PROG) ? CMD_PROG_GO : CMD_ERASE_GO;
            end
          end else begin
            idx <= idx + 1'b1;
            bc_go <= 1'b1; bc_kind <= BK_ADDR;
            bc_tx <= addr_q[{idx[1:0] + 2'd1, 3'b000} +: 8];
          end
        end
        S_DIN: if (bc_fin) begin
          if (idx == len_q - 1'b1) begin
            st <= S_CMD2; bc_go <= 1'b1; bc_kind <= BK_CMD; bc_tx <= CMD_PROG_GO;
          end else begin
            idx <= idx + 1'b1; wr_take <= 1'b1;
            bc_go <= 1'b1; bc_kind <= BK_DIN; bc_tx <= wr_data;
          end
        end
        S_CMD2: if (bc_fin) begin
          st <= S_WAIT; bw_go <= 1'b1;
          bw_lim <= (op_q == OP_PROG) ? TO_W'(PROG_TO) : TO_W'(ERASE_TO);
        end
        S_WAIT: if (bw_fin) begin
          if (bw_tmo) begin
            st <= S_IDLE; done <= 1'b1; done_code <= DC_TMO; nand_ce_n <= 1'b1; nand_wp_n <= 1'b0;
          end else if (op_q != OP_READ) begin
            st <= S_STAT; bc_go <= 1'b1; bc_kind <= BK_CMD; bc_tx <= CMD_STATUS;
          end else if (len_q == '0) begin
            st <= S_IDLE; done <= 1'b1; done_code <= DC_OK; nand_ce_n <= 1'b1;
          end else begin
            st <= S_DOUT; idx <= '0; bc_go <= 1'b1; bc_kind <= BK_DOUT;
          end
        end
        S_DOUT: if (bc_fin) begin
          rd_valid <= 1'b1; rd_data <= bc_rx;
          if (idx == len_q - 1'b1) begin
            st <= S_IDLE; done <= 1'b1; done_code <= DC_OK; nand_ce_n <= 1'b1;
          end else begin
            idx <= idx + 1'b1; bc_go <= 1'b1; bc_kind <= BK_DOUT;
          end
        end
        S_STAT: if (bc_fin) begin
          st <= S_SREAD; bc_go <= 1'b1; bc_kind <= BK_DOUT;
        end
        default: if (bc_fin) begin
          st <= S_IDLE; done <= 1'b1; nand_ce_n <= 1'b1; nand_wp_n <= 1'b0;
          done_code <= bc_rx[0] ? DC_FAIL : DC_OK;
        end
      endcase
    end
  end

  // R7: standby whenever idle
  a_r7_idle_standby: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> nand_ce_n);
  // R5: protection released throughout program and erase
  a_r5_wp_released: assert property (@(posedge clk) disable iff (rst)
    (!nand_ce_n && op_q != OP_READ) |-> nand_wp_n);
  // R10: a refused request leaves the chip deselected
  a_r10_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    (done && done_code == DC_REJ) |-> (nand_ce_n && $past(nand_ce_n)));
  // R4: read data only while selected and reading
  a_r4_rd_valid_ctx: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (op_q == OP_READ));
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  localparam int T_LO = 2;
  localparam int LEN_W = 10;
  localparam int NBLK = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_ready, req_spare = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [NBLK-1:0] mask = 16'h0002;
  logic [7:0] wr_data, rd_data, dq_o, dq_i;
  logic wr_take, rd_valid, done, ce_n, cle, ale, we_n, re_n, wp_n, dq_oe;
  logic [1:0] done_code;
  logic rb_n = 1'b1;

  nand_seq #(.NBLK(NBLK), .PG_PER_BLK(4), .LEN_W(LEN_W), .T_SU(1), .T_LO(T_LO), .T_HI(2),
             .T_WB(4), .PROG_TO(60), .ERASE_TO(80), .RD_TO(60)) u_nand_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_spare(req_spare), .blk_ok_mask(mask),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .done_code(done_code), .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_wp_n(wp_n), .nand_dq_o(dq_o),
    .nand_dq_oe(dq_oe), .nand_dq_i(dq_i), .nand_rb_n(rb_n));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {int kind; logic [7:0] b; logic wp;} ev_t;
  ev_t evq[$];
  logic [7:0] rdq[$];
  int wr_k = 0;
  assign wr_data = 8'h30 + 8'(wr_k);

  // flash model state
  logic [7:0] last_cmd = 8'hFF, stat_byte = 8'h00;
  int addr_cnt = 0, rd_idx = 0, busy_len = 20, busy_dly = 0, busy_left = 0;
  bit busy_pending = 0, ce_low_seen = 0;
  int ev_count = 0, lo_cnt = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  assign dq_i = (last_cmd == 8'h70) ? stat_byte : (8'(rd_idx) ^ 8'hA5);

  // monitor and model
  always @(negedge clk) begin
    if (!rst) begin
      if (!ce_n) ce_low_seen = 1;
      if (wr_take) wr_k++;
      if (busy_pending) begin
        if (busy_dly > 0) begin
          busy_dly--;
          if (busy_dly == 0) rb_n = 1'b0;
        end else if (busy_left > 0) begin
          busy_left--;
          if (busy_left == 0) begin rb_n = 1'b1; busy_pending = 0; end
        end
      end
      if (!we_n || !re_n) lo_cnt++;
      if (we_n && !prev_we) begin
        ev_t e;
        int k;
        ev_count++;
        k = (cle && !ale) ? 0 : (ale && !cle) ? 1 : (!cle && !ale) ? 2 : 9;
        if (evq.size() == 0) chk(0, "R1 unexpected write strobe", k, -1);
        else begin
          e = evq.pop_front();
          chk(k == e.kind && dq_o == e.b, "R1/R2/R3 bus byte kind", {k[7:0], dq_o}, {e.kind[7:0], e.b});
          chk(wp_n == e.wp && !ce_n && re_n, "R5 wp/ce during cycle", {wp_n, ce_n}, {e.wp, 1'b0});
        end
        chk(lo_cnt == T_LO, "R6 write strobe width", lo_cnt, T_LO);
        if (k == 0) begin
          last_cmd = dq_o; addr_cnt = 0; rd_idx = 0;
          if (dq_o == 8'h70) chk(!busy_pending, "R8 status before busy released", busy_pending, 0);
          if (dq_o == 8'h10 || dq_o == 8'hD0) begin
            busy_pending = 1; busy_dly = 2; busy_left = busy_len;
          end
        end else if (k == 1) begin
          addr_cnt++;
          if (addr_cnt == 4 && (last_cmd == 8'h00 || last_cmd == 8'h50)) begin
            busy_pending = 1; busy_dly = 2; busy_left = busy_len;
          end
        end
        lo_cnt = 0;
      end
      if (re_n && !prev_re) begin
        ev_t e;
        ev_count++;
        if (evq.size() == 0) chk(0, "R4 unexpected read strobe", 3, -1);
        else begin
          e = evq.pop_front();
          chk(e.kind == 3 && !cle && !ale && we_n, "R4 read strobe context", {cle, ale, we_n}, 3'b001);
        end
        chk(lo_cnt == T_LO, "R6 read strobe width", lo_cnt, T_LO);
        chk(!busy_pending, "R8 read strobe during busy", busy_pending, 0);
        rd_idx++;
        lo_cnt = 0;
      end
      if (rd_valid) begin
        if (rdq.size() == 0) chk(0, "R4 unexpected rd_valid", rd_data, -1);
        else begin
          logic [7:0] x;
          x = rdq.pop_front();
          chk(rd_data == x, "R4 read data", rd_data, x);
        end
      end
      prev_we = we_n; prev_re = re_n;
    end
  end

  task automatic push(input int kind, input logic [7:0] b, input logic wp);
    ev_t e;
    e.kind = kind; e.b = b; e.wp = wp;
    evq.push_back(e);
  endtask

  // driver: op 0 read, 1 program, 2 erase; codes 0 ok, 1 fail, 2 timeout, 3 reject
  task automatic run(input int op, input logic [31:0] a, input int len, input bit sp,
                     input int exp_code, input string tag);
    logic wp;
    int ev0;
    while (busy_pending) @(negedge clk);
    wp = (op != 0);
    wr_k = 0;
    if (exp_code != 3) begin
      push(0, op == 1 ? 8'h80 : op == 2 ? 8'h60 : (sp ? 8'h50 : 8'h00), wp);
      for (int i = 0; i < 4; i++) push(1, a[8*i +: 8], wp);
      if (op == 0) begin
        for (int i = 0; i < len; i++) begin push(3, 8'h00, wp); rdq.push_back(8'(i) ^ 8'hA5); end
      end else begin
        if (op == 1) begin
          for (int i = 0; i < len; i++) push(2, 8'h30 + 8'(i), wp);
          push(0, 8'h10, wp);
        end else push(0, 8'hD0, wp);
        if (exp_code != 2) begin push(0, 8'h70, wp); push(3, 8'h00, wp); end
      end
    end
    ev0 = ev_count;
    ce_low_seen = 0;
    req_op = 2'(op); req_addr = a; req_len = LEN_W'(len); req_spare = sp; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_code != 3) chk(!req_ready, {"R7 ready low while busy ", tag}, req_ready, 0);
    while (!done) @(negedge clk);
    chk(done_code == 2'(exp_code), {"R12 completion code ", tag}, done_code, exp_code);
    @(negedge clk);
    chk(!done, {"R12 done is a pulse ", tag}, done, 0);
    chk(ce_n && req_ready, {"R7 idle after request ", tag}, {ce_n, req_ready}, 2'b11);
    chk(evq.size() == 0 && rdq.size() == 0, {"R1 all expected cycles seen ", tag}, evq.size(), 0);
    if (exp_code == 3)
      chk(ev_count == ev0 && !ce_low_seen, {"R10/R11 reject without bus activity ", tag}, ev_count - ev0, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    chk(0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(ce_n && !wp_n && we_n && re_n && !cle && !ale && req_ready && !done,
        "R7 reset state", {ce_n, wp_n, we_n, re_n, cle, ale, req_ready, done}, 8'b10110010);
    run(0, 32'h00A1_2345, 4, 0, 0, "R4 main read");
    run(0, 32'h0000_0007, 2, 1, 0, "R1 spare read");
    run(1, 32'h0000_0400, 3, 0, 0, "R3 program main 1");
    run(1, 32'h0000_0400, 3, 0, 0, "R11 program main 2");
    run(1, 32'h0000_0400, 3, 0, 3, "R11 program main 3 over budget");
    run(1, 32'h0000_0400, 2, 1, 0, "R11 spare 1");
    run(1, 32'h0000_0400, 2, 1, 0, "R11 spare 2");
    run(1, 32'h0000_0400, 2, 1, 0, "R11 spare 3");
    run(1, 32'h0000_0400, 2, 1, 3, "R11 spare 4 over budget");
    run(1, 32'h0000_0500, 1, 0, 0, "R11 other page independent");
    run(2, 32'h0000_0400, 0, 0, 0, "R5 erase block 1");
    run(1, 32'h0000_0400, 3, 0, 0, "R11 budget restored by erase");
    run(1, 32'h0000_0800, 2, 0, 3, "R10 program invalid block");
    run(2, 32'h0000_0800, 0, 0, 3, "R10 erase invalid block");
    run(1, 32'h0000_0200, 1, 0, 0, "R10 block zero always valid");
    run(3, 32'h0000_0000, 0, 0, 3, "R12 reserved op");
    stat_byte = 8'h01;
    run(1, 32'h0000_0300, 2, 0, 1, "R9 status fail");
    stat_byte = 8'h00;
    busy_len = 400;
    run(1, 32'h0000_0600, 1, 0, 2, "R8 program timeout");
    run(2, 32'h0000_0400, 0, 0, 2, "R8 erase timeout");
    busy_len = 20;
    run(1, 32'h0000_0700, 0, 0, 0, "R3 zero-length program");
    run(0, 32'h0000_0000, 0, 0, 0, "R4 zero-length read");
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule